// File: doc/BRIEF.md
# Audio Sample Word Formatter

This block sits between the register write port of an audio transmitter and its bit serializer. Software or a DMA engine writes 32-bit words to a common data register. The formatter pulls one audio sample out of each word, according to the configured byte order, justification, container size in bytes and number of valid bits. It left-aligns the sample into a 24-bit audio word, tags it with a channel number and queues it in a small sample FIFO. The serializer drains the FIFO through a valid/ready handshake.

In two-channel mode, successive data writes are assigned to channel 1 and channel 2 in turn, starting with channel 1 after every FIFO clear. In mono mode every sample goes to channel 1. Six status flags report the FIFO state and the error conditions: ready, empty, full, room for a transfer chunk, sticky underrun and sticky overrun. A DMA controller paces its bursts from the chunk flag.

Top module: `audio_word_fmt`

## Requirements
- R1: After reset, `flags` reads 6'h0B, `smp_valid` is low, and the next accepted write goes to channel 1 (`smp_chan` = 0).
- R2: When `cfg_big` = 1, the lowest `cfg_bytes_m1`+1 bytes of the written word are taken in reversed byte order. When `cfg_big` = 0, they are taken as written. Bytes above the container are ignored.
- R3: When `cfg_msb` = 0, the sample occupies the low `cfg_vbits` bits of the container. When `cfg_msb` = 1, it occupies the top `cfg_vbits` bits. The container is (`cfg_bytes_m1`+1)*8 bits wide, and `cfg_vbits` is limited to the container width.
- R4: The sample is placed with its MSB at bit 23 of `smp_data`, and bits below it are filled with zeros. A sample of more than 24 valid bits is cut down to its top 24 bits. The supported widths are 8, 16, 18, 20, 24 and 32.
- R5: When `cfg_dual` = 1, accepted writes alternate `smp_chan` between 0 (channel 1) and 1 (channel 2). When `cfg_dual` = 0, every sample has `smp_chan` = 0.
- R6: Samples leave in write order. `smp_valid` is high whenever the FIFO holds a sample. A sample is removed on a clock edge with `smp_valid` and `smp_ready` both high. A write and a removal in the same cycle leave the fill level unchanged.
- R7: A write while the FIFO is full is dropped and sets the overrun flag (`flags[5]`). The flag stays set until a clear or a reset.
- R8: `smp_ready` high while the FIFO is empty sets the underrun flag (`flags[4]`). The flag stays set until a clear or a reset.
- R9: `flags[0]` (ready) is the inverse of full. `flags[1]` is empty and `flags[2]` is full. `flags[3]` is set when the free space is at least `cfg_chunk`, with a chunk of 0 counted as 1.
- R10: `fifo_clr` empties the FIFO, clears both sticky flags and sends the next write to channel 1. A write in the same cycle as a clear is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 32 | Written data word |
| fifo_clr | input | 1 | FIFO clear and channel pointer restart |
| cfg_dual | input | 1 | 0 mono, 1 two-channel toggle |
| cfg_big | input | 1 | 0 little-endian, 1 big-endian container |
| cfg_msb | input | 1 | 0 LSB-justified, 1 MSB-justified sample |
| cfg_vbits | input | 6 | Valid bits per sample |
| cfg_bytes_m1 | input | 2 | Bytes per sample minus one |
| cfg_chunk | input | 4 | Samples per transfer request |
| smp_valid | output | 1 | A sample is available |
| smp_ready | input | 1 | Serializer takes the sample |
| smp_data | output | 24 | Left-aligned audio sample |
| smp_chan | output | 1 | Channel of the sample (0 = channel 1) |
| flags | output | 6 | {overrun, underrun, chunk, full, empty, ready} |

## Verification
The hardest states to reach are the sticky error states combined with the channel pointer. The bench has to show that a dropped write leaves no trace in the sample stream or in the channel alternation, and that a clear restarts the pointer part-way through a pair. To get there, it fills the FIFO in two-channel mode, writes once more, and then drains the FIFO while checking the order and channel of every sample. It also issues a clear after an odd number of writes, and a clear in the same cycle as a write. A separate table walks the byte-order, justification and width combinations, including a container with junk bits above the sample.

// File: rtl/aw_fmt_pkg.sv
package aw_fmt_pkg;
  localparam int FLAG_W   = 6;
  localparam int F_READY  = 0;
  localparam int F_EMPTY  = 1;
  localparam int F_FULL   = 2;
  localparam int F_CHUNK  = 3;
  localparam int F_UNDR   = 4;
  localparam int F_OVR    = 5;
  typedef logic [FLAG_W-1:0] flags_t;
endpackage

// File: rtl/aw_unpack.sv
module aw_unpack #(
  parameter int DATA_W = 32,
  parameter int SMP_W  = 24
) (
  input  logic [DATA_W-1:0] word,
  input  logic              big,
  input  logic              msb,
  input  logic [5:0]        vbits,
  input  logic [1:0]        bytes_m1,
  output logic [SMP_W-1:0]  smp
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] cont;
  logic [DATA_W-1:0] aligned;
  logic [DATA_W-1:0] keep;
  int                nbytes;
  int                nbits;
  int                vb_eff;
  int                shamt;

  assign nbytes = int'(bytes_m1) + 1;
  assign nbits  = nbytes * 8;
  assign vb_eff = (int'(vbits) > nbits) ? nbits : int'(vbits);

  // one byte lane per generate step: pick direct or mirrored source byte
  for (genvar g = 0; g < NB; g++) begin : g_lane
    int src;
    always_comb begin
      src = big ? (nbytes - 1 - g) : g;
      if (src < 0) src = 0;
      if (g < nbytes) cont[8*g +: 8] = word[8*src +: 8];
      else            cont[8*g +: 8] = 8'h00;
    end
  end

  always_comb begin
    shamt   = msb ? (DATA_W - nbits) : (DATA_W - vb_eff);
    aligned = cont << shamt;
    keep    = ~({DATA_W{1'b1}} >> vb_eff);
    smp     = (aligned & keep) >> (DATA_W - SMP_W);
  end
endmodule

// File: rtl/aw_fifo.sv
module aw_fifo #(
  parameter int W     = 25,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout = mem[rd_ptr];
endmodule

// File: rtl/aw_status.sv
module aw_status
  import aw_fmt_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic [$clog2(DEPTH):0] count,
  input  logic [3:0]             chunk,
  input  logic                   wr_req,
  input  logic                   rd_req,
  output flags_t                 flags
);
  logic ovr_q;
  logic udr_q;
  logic full;
  logic empty;
  int   free_slots;
  int   need;

  assign full       = (int'(count) == DEPTH);
  assign empty      = (count == '0);
  assign free_slots = DEPTH - int'(count);
  assign need       = (chunk == 4'd0) ? 1 : int'(chunk);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ovr_q <= 1'b0;
      udr_q <= 1'b0;
    end else begin
      if (wr_req && full)  ovr_q <= 1'b1;
      if (rd_req && empty) udr_q <= 1'b1;
    end
  end

  always_comb begin
    flags          = '0;
    flags[F_READY] = ~full;
    flags[F_EMPTY] = empty;
    flags[F_FULL]  = full;
    flags[F_CHUNK] = (free_slots >= need);
    flags[F_UNDR]  = udr_q;
    flags[F_OVR]   = ovr_q;
  end
endmodule

// File: rtl/audio_word_fmt.sv
module audio_word_fmt
  import aw_fmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SMP_W  = 24,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fifo_clr,
  input  logic              cfg_dual,
  input  logic              cfg_big,
  input  logic              cfg_msb,
  input  logic [5:0]        cfg_vbits,
  input  logic [1:0]        cfg_bytes_m1,
  input  logic [3:0]        cfg_chunk,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [SMP_W-1:0]  smp_data,
  output logic              smp_chan,
  output logic [5:0]        flags
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam int EW = SMP_W + 1;

  logic [SMP_W-1:0] unpacked;
  logic [EW-1:0]    head;
  logic [CW-1:0]    count;
  flags_t           st;
  logic             chan_q;
  logic             wr_req;
  logic             push;
  logic             pop;

  aw_unpack #(.DATA_W(DATA_W), .SMP_W(SMP_W)) u_unpack (
    .word(wr_data), .big(cfg_big), .msb(cfg_msb),
    .vbits(cfg_vbits), .bytes_m1(cfg_bytes_m1), .smp(unpacked)
  );

  assign wr_req = wr_en & ~fifo_clr;
  assign push   = wr_req & ~st[F_FULL];
  assign pop    = smp_ready & ~st[F_EMPTY] & ~fifo_clr;

  always_ff @(posedge clk) begin
    if (rst || fifo_clr)      chan_q <= 1'b0;
    else if (push && cfg_dual) chan_q <= ~chan_q;
  end

  aw_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(fifo_clr), .push(push),
    .din({cfg_dual & chan_q, unpacked}), .pop(pop),
    .dout(head), .count(count)
  );

  aw_status #(.DEPTH(DEPTH)) u_status (
    .clk(clk), .rst(rst), .clr(fifo_clr), .count(count),
    .chunk(cfg_chunk), .wr_req(wr_req), .rd_req(smp_ready),
    .flags(st)
  );

  assign smp_valid = ~st[F_EMPTY];
  assign smp_data  = head[SMP_W-1:0];
  assign smp_chan  = head[SMP_W];
  assign flags     = st;
endmodule

// File: rtl/aw_fmt_chk.sv
module aw_fmt_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        fifo_clr,
  input logic        smp_valid,
  input logic        smp_ready,
  input logic [23:0] smp_data,
  input logic [5:0]  flags
);
  // R6
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    smp_valid && !smp_ready && !fifo_clr |=> smp_valid && $stable(smp_data));
  // R9
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(flags[2] && flags[1]));
  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && flags[2] && !fifo_clr |=> flags[5]);
  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flags[5] && !fifo_clr |=> flags[5]);
  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flags[4] && !fifo_clr |=> flags[4]);
  // R10
  clear_effect_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |=> flags[1] && !flags[5] && !flags[4] && !smp_valid);
endmodule

bind audio_word_fmt aw_fmt_chk u_aw_fmt_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .fifo_clr(fifo_clr),
  .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
  .flags(flags)
);

// File: tb/tb_audio_word_fmt.sv
`timescale 1ns/1ps
module tb_audio_word_fmt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        fifo_clr = 1'b0;
  logic        cfg_dual = 1'b0;
  logic        cfg_big = 1'b0;
  logic        cfg_msb = 1'b0;
  logic [5:0]  cfg_vbits = 6'd16;
  logic [1:0]  cfg_bytes_m1 = 2'd1;
  logic [3:0]  cfg_chunk = 4'd1;
  logic        smp_valid;
  logic        smp_ready = 1'b0;
  logic [23:0] smp_data;
  logic        smp_chan;
  logic [5:0]  flags;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  audio_word_fmt dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_clr(fifo_clr), .cfg_dual(cfg_dual), .cfg_big(cfg_big),
    .cfg_msb(cfg_msb), .cfg_vbits(cfg_vbits), .cfg_bytes_m1(cfg_bytes_m1),
    .cfg_chunk(cfg_chunk), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .smp_chan(smp_chan), .flags(flags)
  );

  // {big, msb, vbits, bytes_m1, word, expected}
  localparam int NV = 11;
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 1'b0, 6'd16, 2'd1, 32'h0000_1234, 24'h123400},
    {1'b1, 1'b0, 6'd16, 2'd1, 32'h0000_3412, 24'h123400},
    {1'b0, 1'b1, 6'd16, 2'd3, 32'hABCD_5678, 24'hABCD00},
    {1'b0, 1'b0, 6'd24, 2'd2, 32'hFF12_3456, 24'h123456},
    {1'b1, 1'b0, 6'd24, 2'd2, 32'h0056_3412, 24'h123456},
    {1'b0, 1'b0, 6'd8,  2'd0, 32'hFFFF_FFA5, 24'hA50000},
    {1'b0, 1'b0, 6'd32, 2'd3, 32'h89AB_CDEF, 24'h89ABCD},
    {1'b0, 1'b0, 6'd20, 2'd2, 32'hFFFA_BCDE, 24'hABCDE0},
    {1'b0, 1'b1, 6'd18, 2'd3, 32'h1234_5678, 24'h123440},
    {1'b1, 1'b1, 6'd24, 2'd3, 32'h7856_3412, 24'h123456},
    {1'b0, 1'b0, 6'd18, 2'd2, 32'h0003_FFFF, 24'hFFFFC0}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [31:0] w);
    wr_en = 1'b1; wr_data = w;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic do_clr();
    fifo_clr = 1'b1;
    cyc();
    fifo_clr = 1'b0;
  endtask

  task automatic do_pop();
    smp_ready = 1'b1;
    cyc();
    smp_ready = 1'b0;
  endtask

  task automatic pop_chk(input string req, input logic [23:0] d, input logic c);
    chk(req, {31'd0, smp_valid}, 32'd1);
    chk(req, {8'd0, smp_data}, {8'd0, d});
    chk(req, {31'd0, smp_chan}, {31'd0, c});
    do_pop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 flags", {26'd0, flags}, 32'h0B);
    chk("R1 valid", {31'd0, smp_valid}, 32'd0);

    // R2 R3 R4 extraction table
    for (int i = 0; i < NV; i++) begin
      do_clr();
      cfg_big      = VEC[i][65];
      cfg_msb      = VEC[i][64];
      cfg_vbits    = VEC[i][63:58];
      cfg_bytes_m1 = VEC[i][57:56];
      do_write(VEC[i][55:24]);
      chk("R2 R3 R4 sample", {8'd0, smp_data}, {8'd0, VEC[i][23:0]});
      chk("R1 first channel", {31'd0, smp_chan}, 32'd0);
    end

    // R5 R6 two-channel fill, R9 full, R7 overrun
    cfg_big = 1'b0; cfg_msb = 1'b0; cfg_vbits = 6'd16; cfg_bytes_m1 = 2'd1;
    cfg_dual = 1'b1; cfg_chunk = 4'd1;
    do_clr();
    do_write(32'h1111); do_write(32'h2222);
    do_write(32'h3333); do_write(32'h4444);
    chk("R9 full flags", {26'd0, flags}, 32'h04);
    do_write(32'h5555);
    chk("R7 overrun flags", {26'd0, flags}, 32'h24);
    pop_chk("R5 R6 first", 24'h111100, 1'b0);
    pop_chk("R5 R6 second", 24'h222200, 1'b1);
    pop_chk("R5 R6 third", 24'h333300, 1'b0);
    pop_chk("R5 R7 fourth", 24'h444400, 1'b1);
    chk("R7 dropped write absent", {31'd0, smp_valid}, 32'd0);
    chk("R7 sticky overrun", {26'd0, flags}, 32'h2B);

    // R8 underrun
    do_pop();
    chk("R8 underrun", {26'd0, flags}, 32'h3B);
    cyc();
    chk("R8 sticky", {26'd0, flags}, 32'h3B);
    do_clr();
    chk("R10 clear flags", {26'd0, flags}, 32'h0B);

    // R9 chunk flag
    cfg_chunk = 4'd2;
    do_write(32'h0001); do_write(32'h0002);
    chk("R9 chunk room", {26'd0, flags}, 32'h09);
    do_write(32'h0003);
    chk("R9 chunk no room", {26'd0, flags}, 32'h01);

    // R10 clear restarts toggle
    do_clr();
    do_write(32'h00AA); do_write(32'h00BB); do_write(32'h00CC);
    do_clr();
    do_write(32'h00DD);
    pop_chk("R10 toggle restart", 24'h00DD00, 1'b0);

    // R5 mono
    cfg_dual = 1'b0;
    do_clr();
    do_write(32'h0101); do_write(32'h0202);
    pop_chk("R5 mono a", 24'h010100, 1'b0);
    pop_chk("R5 mono b", 24'h020200, 1'b0);

    // R10 write during clear discarded
    do_write(32'h0303);
    fifo_clr = 1'b1; wr_en = 1'b1; wr_data = 32'h0404;
    cyc();
    fifo_clr = 1'b0; wr_en = 1'b0;
    chk("R10 write with clear", {26'd0, flags}, 32'h0B);
    chk("R10 valid", {31'd0, smp_valid}, 32'd0);

    // R6 simultaneous write and removal
    do_write(32'h0505);
    wr_en = 1'b1; wr_data = 32'h0606; smp_ready = 1'b1;
    cyc();
    wr_en = 1'b0; smp_ready = 1'b0;
    chk("R6 level kept", {26'd0, flags}, 32'h09);
    pop_chk("R6 new head", 24'h060600, 1'b0);

    finish_run();
  end
endmodule